// File: doc/BRIEF.md
# Zoomed Segment Read Address Generator

This block produces the read addresses for a stored video field so that a chosen part of it fills the screen at double size. With magnification on, every source pixel address is held for two consecutive pixel clocks and every source line address is held for two consecutive output lines. With magnification off, the pixel address steps once per clock and the line address steps once per line, both starting from zero.

The segment origin comes from a grid of 8 vertical by 12 horizontal positions. The horizontal origin is the position code times 32 pixels. The vertical origin is the code times 20 lines for the 288-line field (50 Hz) or times 17 lines for the 243-line field (60 Hz). The magnification enable, both position codes and the field-standard select are captured only on the field-start strobe, so the segment never moves within a field.

The address output behaves as a stream source. `addr_valid` follows `line_active` in the same cycle. It has no ready input, because the display raster cannot be stalled, so no back-pressure exists.

Top module: `zoom_addr_gen`

## Requirements
- R1: After reset, `pix_addr`, `line_addr`, `addr_valid` and `zoom_active` are all 0.
- R2: With magnification off, `addr_valid` equals `line_active` in the same cycle. The pixel address is 0 in the first active cycle of a line and rises by 1 in each later active cycle.
- R3: With magnification off, `line_addr` is 0 after a field start and rises by 1 after each line ends. A line ends when `line_active` falls.
- R4: With magnification on, the first active cycle of a line shows `hpos`×32. Each pixel address is held for exactly two active cycles, then rises by 1.
- R5: With magnification on, the first line of a field shows `vpos`×20 when `std_sel`=0 (288 lines) or `vpos`×17 when `std_sel`=1 (243 lines). Each line address is shown for two output lines, then rises by 1.
- R6: Horizontal codes 12 to 15 behave as code 11 (origin 352).
- R7: `zoom_en`, `vpos`, `hpos` and `std_sel` take effect only in a cycle with `field_start` high. `zoom_active` shows the captured enable from the next cycle onward and stays unchanged otherwise.
- R8: `pix_addr` never exceeds 719. `line_addr` never exceeds 287 (`std_sel`=0) or 242 (`std_sel`=1), and both hold at that last value when the count runs past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_active | input | 1 | High during the active part of each output line |
| field_start | input | 1 | One-cycle strobe at the start of each output field, in blanking |
| zoom_en | input | 1 | Magnification request |
| std_sel | input | 1 | 0: 288-line field, 1: 243-line field |
| vpos | input | 3 | Vertical segment position code 0..7 |
| hpos | input | 4 | Horizontal segment position code 0..11 (12..15 clamp to 11) |
| addr_valid | output | 1 | Addresses valid, same cycle as `line_active` |
| pix_addr | output | 10 | Stored pixel address |
| line_addr | output | 9 | Stored line address |
| zoom_active | output | 1 | Captured magnification state |

## Verification
The pixel address is due in the same cycle as the matching active input cycle, because it is built from counters that advanced on the previous edges. The line address is due one cycle after the first blanking cycle, since the line end is detected from a registered copy of `line_active`. `zoom_active` and new origins are due one cycle after the `field_start` cycle. The bench changes inputs on falling clock edges and reads outputs just after them. It keeps at least three blanking cycles between lines, so every line-address check falls after the line counter has moved.

// File: rtl/zoom_pkg.sv
package zoom_pkg;
  localparam int unsigned DEF_PIX_PER_LINE = 720;
  localparam int unsigned DEF_LINES_STD0   = 288;
  localparam int unsigned DEF_LINES_STD1   = 243;
  localparam int unsigned DEF_H_CODES      = 12;
  localparam int unsigned DEF_V_CODES      = 8;
  localparam int unsigned DEF_H_STEP       = 32;
  localparam int unsigned DEF_V_STEP_STD0  = 20;
  localparam int unsigned DEF_V_STEP_STD1  = 17;

  typedef enum logic {AXIS_PLAIN = 1'b0, AXIS_DOUBLE = 1'b1} axis_mode_e;
endpackage

// File: rtl/zoom_cfg_latch.sv
module zoom_cfg_latch #(
  parameter int unsigned H_CODES = zoom_pkg::DEF_H_CODES,
  parameter int unsigned V_CODES = zoom_pkg::DEF_V_CODES,
  parameter int unsigned H_STEP  = zoom_pkg::DEF_H_STEP,
  parameter int unsigned V_STEP0 = zoom_pkg::DEF_V_STEP_STD0,
  parameter int unsigned V_STEP1 = zoom_pkg::DEF_V_STEP_STD1,
  parameter int unsigned LINES0  = zoom_pkg::DEF_LINES_STD0,
  parameter int unsigned LINES1  = zoom_pkg::DEF_LINES_STD1,
  parameter int unsigned PIX_W   = 10,
  parameter int unsigned LINE_W  = 9,
  localparam int unsigned HC_W   = $clog2(H_CODES),
  localparam int unsigned VC_W   = $clog2(V_CODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              zoom_en,
  input  logic              std_sel,
  input  logic [VC_W-1:0]   vpos,
  input  logic [HC_W-1:0]   hpos,
  output zoom_pkg::axis_mode_e mode_q,
  output logic [PIX_W-1:0]  h_origin_q,
  output logic [LINE_W-1:0] v_origin_q,
  output logic [LINE_W-1:0] v_limit_q
);
  localparam logic [HC_W-1:0] H_LAST = HC_W'(H_CODES - 1);

  logic [HC_W-1:0]   hcode_c;
  logic [PIX_W-1:0]  h_org_d;
  logic [LINE_W-1:0] v_org_d;
  logic [LINE_W-1:0] v_lim_d;

  always_comb begin
    hcode_c = (hpos > H_LAST) ? H_LAST : hpos;
    h_org_d = PIX_W'(hcode_c) * PIX_W'(H_STEP);
    v_org_d = LINE_W'(vpos) * (std_sel ? LINE_W'(V_STEP1) : LINE_W'(V_STEP0));
    v_lim_d = std_sel ? LINE_W'(LINES1 - 1) : LINE_W'(LINES0 - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= zoom_pkg::AXIS_PLAIN;
      h_origin_q <= '0;
      v_origin_q <= '0;
      v_limit_q  <= LINE_W'(LINES0 - 1);
    end else if (field_start) begin
      mode_q     <= zoom_en ? zoom_pkg::AXIS_DOUBLE : zoom_pkg::AXIS_PLAIN;
      h_origin_q <= zoom_en ? h_org_d : '0;
      v_origin_q <= zoom_en ? v_org_d : '0;
      v_limit_q  <= v_lim_d;
    end
  end
endmodule

// File: rtl/zoom_axis_counter.sv
module zoom_axis_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         advance,
  input  zoom_pkg::axis_mode_e mode,
  input  logic [W-1:0] origin,
  input  logic [W-1:0] limit,
  output logic [W-1:0] addr
);
  logic [W-1:0] cnt_q;
  logic         half_q;
  logic [W:0]   sum_c;
  logic         at_end_c;

  always_comb begin
    sum_c    = {1'b0, origin} + {1'b0, cnt_q};
    at_end_c = (sum_c >= {1'b0, limit});
    addr     = at_end_c ? limit : sum_c[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (advance) begin
      if (mode == zoom_pkg::AXIS_PLAIN || half_q) begin
        half_q <= 1'b0;
        if (!at_end_c) cnt_q <= cnt_q + 1'b1;
      end else begin
        half_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/zoom_addr_gen.sv
module zoom_addr_gen #(
  parameter int unsigned PIX_PER_LINE = zoom_pkg::DEF_PIX_PER_LINE,
  parameter int unsigned LINES0       = zoom_pkg::DEF_LINES_STD0,
  parameter int unsigned LINES1       = zoom_pkg::DEF_LINES_STD1,
  parameter int unsigned H_CODES      = zoom_pkg::DEF_H_CODES,
  parameter int unsigned V_CODES      = zoom_pkg::DEF_V_CODES,
  parameter int unsigned H_STEP       = zoom_pkg::DEF_H_STEP,
  parameter int unsigned V_STEP0      = zoom_pkg::DEF_V_STEP_STD0,
  parameter int unsigned V_STEP1      = zoom_pkg::DEF_V_STEP_STD1,
  localparam int unsigned PIX_W  = $clog2(PIX_PER_LINE),
  localparam int unsigned LINE_W = $clog2(LINES0 > LINES1 ? LINES0 : LINES1),
  localparam int unsigned HC_W   = $clog2(H_CODES),
  localparam int unsigned VC_W   = $clog2(V_CODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_active,
  input  logic              field_start,
  input  logic              zoom_en,
  input  logic              std_sel,
  input  logic [VC_W-1:0]   vpos,
  input  logic [HC_W-1:0]   hpos,
  output logic              addr_valid,
  output logic [PIX_W-1:0]  pix_addr,
  output logic [LINE_W-1:0] line_addr,
  output logic              zoom_active
);
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_PER_LINE - 1);

  zoom_pkg::axis_mode_e mode_q;
  logic [PIX_W-1:0]  h_origin_q;
  logic [LINE_W-1:0] v_origin_q;
  logic [LINE_W-1:0] v_limit_q;
  logic              la_q;
  logic              line_end_c;

  zoom_cfg_latch #(
    .H_CODES(H_CODES), .V_CODES(V_CODES), .H_STEP(H_STEP),
    .V_STEP0(V_STEP0), .V_STEP1(V_STEP1), .LINES0(LINES0), .LINES1(LINES1),
    .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .zoom_en(zoom_en),
    .std_sel(std_sel), .vpos(vpos), .hpos(hpos), .mode_q(mode_q),
    .h_origin_q(h_origin_q), .v_origin_q(v_origin_q), .v_limit_q(v_limit_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) la_q <= 1'b0;
    else        la_q <= line_active;
  end

  assign line_end_c = la_q & ~line_active;

  zoom_axis_counter #(.W(PIX_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .restart(~line_active), .advance(line_active),
    .mode(mode_q), .origin(h_origin_q), .limit(PIX_LAST), .addr(pix_addr)
  );

  zoom_axis_counter #(.W(LINE_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .restart(field_start), .advance(line_end_c),
    .mode(mode_q), .origin(v_origin_q), .limit(v_limit_q), .addr(line_addr)
  );

  assign addr_valid  = line_active;
  assign zoom_active = (mode_q == zoom_pkg::AXIS_DOUBLE);
endmodule

// File: rtl/zoom_addr_chk.sv
module zoom_addr_chk #(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned LINE_W = 9,
  parameter int unsigned PIX_PER_LINE = 720,
  parameter int unsigned LINES_MAX    = 288
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_start,
  input logic              addr_valid,
  input logic [PIX_W-1:0]  pix_addr,
  input logic [LINE_W-1:0] line_addr,
  input logic              zoom_active
);
  a_r2_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid) && !zoom_active && $stable(zoom_active)) |->
      (pix_addr == $past(pix_addr) + 1'b1 || pix_addr == PIX_W'(PIX_PER_LINE - 1)));

  a_r2_line_head: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(addr_valid) && !zoom_active) |-> (pix_addr == '0));

  a_r4_zoom_step: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid) && zoom_active && $stable(zoom_active)) |->
      (pix_addr >= $past(pix_addr) && pix_addr <= $past(pix_addr) + 1'b1));

  a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid)) |-> $stable(line_addr));

  a_r7_zoom_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(zoom_active));

  a_r8_pix_limit: assert property (@(posedge clk) disable iff (!rst_n)
    pix_addr <= PIX_W'(PIX_PER_LINE - 1));

  a_r8_line_limit: assert property (@(posedge clk) disable iff (!rst_n)
    line_addr <= LINE_W'(LINES_MAX - 1));
endmodule

bind zoom_addr_gen zoom_addr_chk #(
  .PIX_W(PIX_W), .LINE_W(LINE_W), .PIX_PER_LINE(PIX_PER_LINE),
  .LINES_MAX(LINES0 > LINES1 ? LINES0 : LINES1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .field_start(field_start), .addr_valid(addr_valid),
  .pix_addr(pix_addr), .line_addr(line_addr), .zoom_active(zoom_active)
);

// File: tb/zoom_addr_gen_test.sv
module zoom_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_active = 1'b0, field_start = 1'b0, zoom_en = 1'b0, std_sel = 1'b0;
  logic [2:0] vpos = '0;
  logic [3:0] hpos = '0;
  logic addr_valid, zoom_active;
  logic [9:0] pix_addr;
  logic [8:0] line_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  zoom_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .line_active(line_active), .field_start(field_start),
    .zoom_en(zoom_en), .std_sel(std_sel), .vpos(vpos), .hpos(hpos),
    .addr_valid(addr_valid), .pix_addr(pix_addr), .line_addr(line_addr),
    .zoom_active(zoom_active)
  );

  // {zoom, std, vpos[3], hpos[4], expected h origin[10], expected v origin[9]}
  localparam logic [27:0] VEC [0:5] = '{
    {1'b0, 1'b0, 3'd3, 4'd5,  10'd0,   9'd0},
    {1'b1, 1'b0, 3'd0, 4'd0,  10'd0,   9'd0},
    {1'b1, 1'b0, 3'd3, 4'd5,  10'd160, 9'd60},
    {1'b1, 1'b1, 3'd7, 4'd11, 10'd352, 9'd119},
    {1'b1, 1'b0, 3'd7, 4'd14, 10'd352, 9'd140},
    {1'b1, 1'b1, 3'd2, 4'd1,  10'd32,  9'd34}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic blank(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_active = 1'b0;
    end
  endtask

  task automatic pulse_field();
    @(negedge clk);
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    blank(2);
  endtask

  // One line; checks every pixel and the line address (R2/R3 plain, R4/R5 zoom, R8 limits)
  task automatic run_line(int n_act, bit zm, int ho, int vo, int lidx, int lim);
    int exp_p, exp_l;
    exp_l = zm ? vo + lidx / 2 : lidx;
    if (exp_l > lim) exp_l = lim;
    for (int k = 0; k < n_act; k++) begin
      @(negedge clk);
      line_active = 1'b1;
      #1;
      exp_p = zm ? ho + k / 2 : k;
      if (exp_p > 719) exp_p = 719;
      chk(zm ? "R4 zoom pixel" : "R2 plain pixel", int'(pix_addr), exp_p);
      if (k == 0) begin
        chk(zm ? "R5 zoom line" : "R3 plain line", int'(line_addr), exp_l);
        chk("R2 valid", int'(addr_valid), 1);
      end
    end
    blank(3);
  endtask

  initial begin
    #2_000_000;
    $display("FAIL watchdog: actual timeout expected completion");
    n_chk++;
    n_fail++;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pix", int'(pix_addr), 0);
    chk("R1 line", int'(line_addr), 0);
    chk("R1 valid", int'(addr_valid), 0);
    chk("R1 zoom", int'(zoom_active), 0);
    @(negedge clk);
    rst_n = 1'b1;
    blank(2);

    // Table walk: origins, doubling, clamp of horizontal codes (R6)
    foreach (VEC[i]) begin
      zoom_en = VEC[i][27];
      std_sel = VEC[i][26];
      vpos    = VEC[i][25:23];
      hpos    = VEC[i][22:19];
      pulse_field();
      chk("R7 zoom flag", int'(zoom_active), int'(VEC[i][27]));
      for (int l = 0; l < 4; l++)
        run_line(24, VEC[i][27], int'(VEC[i][18:9]), int'(VEC[i][8:0]), l,
                 VEC[i][26] ? 242 : 287);
    end

    // R6: code 15 behaves as code 11
    zoom_en = 1'b1; std_sel = 1'b0; vpos = 3'd0; hpos = 4'd15;
    pulse_field();
    run_line(4, 1'b1, 352, 0, 0, 287);

    // R8: pixel saturation in a plain over-long line
    zoom_en = 1'b0; hpos = 4'd0;
    pulse_field();
    run_line(730, 1'b0, 0, 0, 0, 287);

    // R8: line saturation in the 243-line field
    std_sel = 1'b1;
    pulse_field();
    for (int l = 0; l < 250; l++) run_line(2, 1'b0, 0, 0, l, 242);

    // R7: mid-field changes are ignored until the next field start
    zoom_en = 1'b1; std_sel = 1'b0; vpos = 3'd1; hpos = 4'd1;
    pulse_field();
    run_line(6, 1'b1, 32, 20, 0, 287);
    zoom_en = 1'b0; vpos = 3'd5; hpos = 4'd9; std_sel = 1'b1;
    blank(2);
    chk("R7 zoom held", int'(zoom_active), 1);
    run_line(6, 1'b1, 32, 20, 1, 287);
    run_line(6, 1'b1, 32, 20, 2, 287);
    pulse_field();
    chk("R7 zoom update", int'(zoom_active), 0);
    run_line(6, 1'b0, 0, 0, 0, 242);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule